// File: doc/BRIEF.md
# I2C Slave Status Flag Monitor

This block watches the serial clock and data lines of an I2C bus, together with the strobes a host raises when it touches the data buffer or writes the second control register. From these it keeps the status bits a serial bus interface reports: arbitration lost, master and transmitter mode, addressed as slave, general call seen, and the last bit sampled. The two bus lines pass through a synchronizer first. Start and stop conditions are then decoded, bits are counted and shifted in, and the first byte after each start is compared with a programmable 7-bit own address.

A second mode skips address recognition: any first byte marks the block as addressed. When the block is master transmitter and releases SDA high, but another device holds it low, the block records the loss of arbitration and drops back to slave receiver. While the flag is set it asks the clock generator to stop and the SDA driver to stay released.

Top module: `i2c_status_monitor`

## Requirements
- R1: When a rising SCL edge samples SDA low while the block is master (`master_mode`=1), transmitter (`transmit_mode`=1) and drives `tx_sda`=1, `arb_lost` becomes 1 and both `master_mode` and `transmit_mode` become 0. If SDA is sampled high in that situation, `arb_lost` stays 0.
- R2: Any pulse on `dbuf_rd`, `dbuf_wr` or `ctrl2_wr` clears `arb_lost`. A `ctrl2_wr` pulse loads `master_mode` from `ctrl2_mst` and `transmit_mode` from `ctrl2_trx`.
- R3: `master_halt` is 1 exactly while `arb_lost` is 1. This requests that the clock generator stops and that SDA is held released.
- R4: With `addr_free`=0 and slave mode, if bits 7..1 of the first byte after a start equal `slave_addr`, `addressed` becomes 1 and `transmit_mode` takes bit 0 of that byte (the direction bit).
- R5: In slave mode, a first byte of all zeros after a start sets `general_call` to 1. With `addr_free`=0 it also sets `addressed`, and `transmit_mode` stays 0.
- R6: A first byte that neither matches nor is zero leaves `addressed` at 0. While `master_mode`=1, no byte sets `addressed`.
- R7: With `addr_free`=1 and slave mode, `addressed` becomes 1 after the first byte following a start, whatever its value.
- R8: A pulse on `dbuf_rd` or `dbuf_wr` clears `addressed`. A `ctrl2_wr` pulse alone does not clear it.
- R9: `general_call` clears on a start condition (SDA falls while SCL is high) or a stop condition (SDA rises while SCL is high).
- R10: `last_bit` holds the SDA level sampled at the most recent rising SCL edge. After the ninth edge of a byte, this is the acknowledge bit.
- R11: `byte_done` pulses for one clock after every ninth rising SCL edge. `rx_byte` then holds the first eight sampled bits, with the first bit received as bit 7.
- R12: A start condition in the middle of a byte restarts bit counting. The next eight bits form a new first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_pin | input | 1 | SCL line level, asynchronous |
| sda_pin | input | 1 | SDA line level, asynchronous |
| tx_sda | input | 1 | Level the block's own SDA driver is putting out |
| slave_addr | input | 7 | Own slave address |
| addr_free | input | 1 | 1 = accept any first byte without address recognition |
| dbuf_rd | input | 1 | Host read of the data buffer, one-cycle pulse |
| dbuf_wr | input | 1 | Host write of the data buffer, one-cycle pulse |
| ctrl2_wr | input | 1 | Host write of control register 2, one-cycle pulse |
| ctrl2_mst | input | 1 | Master bit value written with `ctrl2_wr` |
| ctrl2_trx | input | 1 | Transmitter bit value written with `ctrl2_wr` |
| arb_lost | output | 1 | Arbitration lost flag |
| master_mode | output | 1 | Master mode bit |
| transmit_mode | output | 1 | Transmitter mode bit |
| addressed | output | 1 | Addressed-as-slave flag |
| general_call | output | 1 | General call detected flag |
| last_bit | output | 1 | SDA level at the last rising SCL edge |
| byte_done | output | 1 | One-cycle pulse after the ninth SCL rise |
| rx_byte | output | 8 | Most recently received byte |
| master_halt | output | 1 | Stop clock output and keep SDA released |

## Verification
The hardest case to reach is a loss of arbitration. It needs the block to be master transmitter, with its own `tx_sda` high, at the same rising SCL edge at which the bus shows SDA low. The bench first writes control register 2 to enter master transmit, then plays the part of a competing master that pulls SDA low during the first bit. A repeated start in the middle of a byte is also driven on purpose, to show that bit counting restarts. Random address, direction, acknowledge and mode choices cover the address-recognition paths.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_evt_t;
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '1;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '1;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cmon_bus_events.sv
module i2cmon_bus_events
  import i2cmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt.scl_rise = scl_s && !scl_q;
    evt.start    = scl_s && scl_q && sda_q && !sda_s;
    evt.stop     = scl_s && scl_q && !sda_q && sda_s;
  end

  // start and stop can never be seen together
  assert_start_stop_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(evt.start && evt.stop));
endmodule

// File: rtl/i2cmon_shifter.sv
module i2cmon_shifter
  import i2cmon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic              sda_s,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              first_done,
  output logic              last_bit
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] cnt;
  logic             first;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      first      <= 1'b0;
      rx_byte    <= '0;
      byte_done  <= 1'b0;
      first_done <= 1'b0;
      last_bit   <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (evt.start) begin
        cnt   <= '0;
        first <= 1'b1;
      end else if (evt.stop) begin
        cnt   <= '0;
        first <= 1'b0;
      end else if (evt.scl_rise) begin
        last_bit <= sda_s;
        if (cnt == CNT_W'(DATA_W)) begin
          cnt        <= '0;
          byte_done  <= 1'b1;
          first_done <= first;
          first      <= 1'b0;
        end else begin
          rx_byte <= {rx_byte[DATA_W-2:0], sda_s};
          cnt     <= cnt + 1'b1;
        end
      end
    end
  end

  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DATA_W));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);
  assert_start_resets_R12: assert property (@(posedge clk) disable iff (rst)
    evt.start |=> (cnt == '0) && !byte_done);
endmodule

// File: rtl/i2cmon_flags.sv
module i2cmon_flags
  import i2cmon_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic              sda_s,
  input  logic              tx_sda,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              addr_free,
  input  logic              dbuf_rd,
  input  logic              dbuf_wr,
  input  logic              ctrl2_wr,
  input  logic              ctrl2_mst,
  input  logic              ctrl2_trx,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              byte_done,
  input  logic              first_done,
  output logic              al_q,
  output logic              mst_q,
  output logic              trx_q,
  output logic              aas_q,
  output logic              gc_q
);
  logic arb_evt, al_clr, aas_clr, eval, addr_hit, gc_hit, aas_set;

  always_comb begin
    arb_evt  = evt.scl_rise && mst_q && trx_q && tx_sda && !sda_s;
    al_clr   = dbuf_rd || dbuf_wr || ctrl2_wr;
    aas_clr  = dbuf_rd || dbuf_wr;
    eval     = byte_done && first_done && !mst_q;
    addr_hit = rx_byte[DATA_W-1:DATA_W-ADDR_W] == slave_addr;
    gc_hit   = rx_byte == '0;
    aas_set  = eval && (addr_free || addr_hit || gc_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q  <= 1'b0;
      mst_q <= 1'b0;
      trx_q <= 1'b0;
      aas_q <= 1'b0;
      gc_q  <= 1'b0;
    end else begin
      if (ctrl2_wr) begin
        mst_q <= ctrl2_mst;
        trx_q <= ctrl2_trx;
      end
      if (eval && !addr_free && addr_hit && !gc_hit)
        trx_q <= rx_byte[0];
      if (arb_evt) begin
        mst_q <= 1'b0;
        trx_q <= 1'b0;
      end

      if (arb_evt)     al_q <= 1'b1;
      else if (al_clr) al_q <= 1'b0;

      if (aas_set)      aas_q <= 1'b1;
      else if (aas_clr) aas_q <= 1'b0;

      if (eval && gc_hit)             gc_q <= 1'b1;
      else if (evt.start || evt.stop) gc_q <= 1'b0;
    end
  end

  assert_al_not_master_R1: assert property (@(posedge clk) disable iff (rst)
    al_q |-> !mst_q);
  assert_al_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    al_clr && !arb_evt |=> !al_q);
  assert_aas_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    aas_clr && !aas_set |=> !aas_q);
  assert_gc_cleared_R9: assert property (@(posedge clk) disable iff (rst)
    (evt.start || evt.stop) && !eval |=> !gc_q);
  assert_no_aas_master_R6: assert property (@(posedge clk) disable iff (rst)
    mst_q && !aas_q && !ctrl2_wr |=> !aas_q);
endmodule

// File: rtl/i2c_status_monitor.sv
module i2c_status_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_pin,
  input  logic              sda_pin,
  input  logic              tx_sda,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              addr_free,
  input  logic              dbuf_rd,
  input  logic              dbuf_wr,
  input  logic              ctrl2_wr,
  input  logic              ctrl2_mst,
  input  logic              ctrl2_trx,
  output logic              arb_lost,
  output logic              master_mode,
  output logic              transmit_mode,
  output logic              addressed,
  output logic              general_call,
  output logic              last_bit,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              master_halt
);
  logic [1:0] lines_s;
  bus_evt_t   evt;
  logic       first_done;
  logic       al_q;

  i2cmon_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_pin, sda_pin}), .q(lines_s)
  );

  i2cmon_bus_events u_evt (
    .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]), .evt(evt)
  );

  i2cmon_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .evt(evt), .sda_s(lines_s[0]),
    .rx_byte(rx_byte), .byte_done(byte_done), .first_done(first_done),
    .last_bit(last_bit)
  );

  i2cmon_flags #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .evt(evt), .sda_s(lines_s[0]), .tx_sda(tx_sda),
    .slave_addr(slave_addr), .addr_free(addr_free),
    .dbuf_rd(dbuf_rd), .dbuf_wr(dbuf_wr), .ctrl2_wr(ctrl2_wr),
    .ctrl2_mst(ctrl2_mst), .ctrl2_trx(ctrl2_trx),
    .rx_byte(rx_byte), .byte_done(byte_done), .first_done(first_done),
    .al_q(al_q), .mst_q(master_mode), .trx_q(transmit_mode),
    .aas_q(addressed), .gc_q(general_call)
  );

  assign arb_lost    = al_q;
  assign master_halt = al_q;

  assert_halt_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    master_halt == arb_lost);
endmodule

// File: tb/i2c_status_monitor_bench.sv
`timescale 1ns/1ps
module i2c_status_monitor_bench;
  localparam int PH = 8;

  logic clk = 1'b0;
  logic rst;
  logic scl_pin, sda_pin, tx_sda, addr_free;
  logic [6:0] slave_addr;
  logic dbuf_rd, dbuf_wr, ctrl2_wr, ctrl2_mst, ctrl2_trx;
  logic arb_lost, master_mode, transmit_mode, addressed, general_call;
  logic last_bit, byte_done, master_halt;
  logic [7:0] rx_byte;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  int unsigned done_cnt = 0;
  int unsigned done_base;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  i2c_status_monitor u_i2c_status_monitor (
    .clk(clk), .rst(rst), .scl_pin(scl_pin), .sda_pin(sda_pin), .tx_sda(tx_sda),
    .slave_addr(slave_addr), .addr_free(addr_free),
    .dbuf_rd(dbuf_rd), .dbuf_wr(dbuf_wr), .ctrl2_wr(ctrl2_wr),
    .ctrl2_mst(ctrl2_mst), .ctrl2_trx(ctrl2_trx),
    .arb_lost(arb_lost), .master_mode(master_mode), .transmit_mode(transmit_mode),
    .addressed(addressed), .general_call(general_call), .last_bit(last_bit),
    .byte_done(byte_done), .rx_byte(rx_byte), .master_halt(master_halt)
  );

  always @(posedge clk) if (!rst && byte_done) done_cnt <= done_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_pin = 1'b1; wt(PH);
    scl_pin = 1'b1; wt(PH);
    sda_pin = 1'b0; wt(PH);
    scl_pin = 1'b0; wt(PH);
  endtask

  task automatic bus_stop();
    sda_pin = 1'b0; wt(PH);
    scl_pin = 1'b1; wt(PH);
    sda_pin = 1'b1; wt(PH);
  endtask

  task automatic bus_bit(input logic b);
    sda_pin = b;    wt(PH);
    scl_pin = 1'b1; wt(PH);
    scl_pin = 1'b0; wt(PH);
  endtask

  task automatic bus_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(ack);
  endtask

  task automatic host_pulse(input int which, input logic m, input logic t);
    @(negedge clk);
    ctrl2_mst = m; ctrl2_trx = t;
    case (which)
      0: dbuf_rd = 1'b1;
      1: dbuf_wr = 1'b1;
      default: ctrl2_wr = 1'b1;
    endcase
    @(negedge clk);
    dbuf_rd = 1'b0; dbuf_wr = 1'b0; ctrl2_wr = 1'b0;
    wt(2);
  endtask

  function automatic logic exp_aas(input logic [7:0] v, input logic [6:0] a, input logic f);
    return f || (v[7:1] == a) || (v == 8'h00);
  endfunction

  function automatic logic exp_trx(input logic [7:0] v, input logic [6:0] a, input logic f);
    return !f && (v != 8'h00) && (v[7:1] == a) && v[0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [7:0] v;
    logic [6:0] a;
    logic f, ack;
    seed = $urandom(32'd2024);
    rst = 1'b1; scl_pin = 1'b1; sda_pin = 1'b1; tx_sda = 1'b1;
    slave_addr = 7'h2A; addr_free = 1'b0;
    dbuf_rd = 1'b0; dbuf_wr = 1'b0; ctrl2_wr = 1'b0; ctrl2_mst = 1'b0; ctrl2_trx = 1'b0;
    wt(5); rst = 1'b0; wt(4);

    // reset state
    chk("R1 reset arb_lost", arb_lost, 0);
    chk("R2 reset master", master_mode, 0);
    chk("R3 reset halt", master_halt, 0);
    chk("R4 reset addressed", addressed, 0);
    chk("R5 reset general_call", general_call, 0);

    // directed: address match with read direction
    done_base = done_cnt;
    bus_start(); bus_byte({7'h2A, 1'b1}, 1'b0);
    chk("R4 match addressed", addressed, 1);
    chk("R4 match trx from dir bit", transmit_mode, 1);
    chk("R10 ack bit low", last_bit, 0);
    chk("R11 rx_byte", rx_byte, 8'h55);
    chk("R11 one byte_done", done_cnt - done_base, 1);
    host_pulse(2, 1'b0, 1'b0);
    chk("R8 ctrl2 keeps addressed", addressed, 1);
    host_pulse(1, 1'b0, 1'b0);
    chk("R8 dbuf write clears addressed", addressed, 0);
    bus_stop();

    // directed: general call, then clear by start
    bus_start(); bus_byte(8'h00, 1'b1);
    chk("R5 general_call set", general_call, 1);
    chk("R5 addressed by general call", addressed, 1);
    chk("R5 trx stays 0", transmit_mode, 0);
    chk("R10 ack bit high", last_bit, 1);
    host_pulse(0, 1'b0, 1'b0);
    chk("R8 dbuf read clears addressed", addressed, 0);
    bus_start();
    chk("R9 start clears general_call", general_call, 0);
    bus_byte(8'h00, 1'b0);
    bus_stop();
    chk("R9 stop clears general_call", general_call, 0);
    host_pulse(0, 1'b0, 1'b0);

    // directed: repeated start in the middle of a byte
    bus_start(); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    done_base = done_cnt;
    bus_start(); bus_byte({7'h2A, 1'b0}, 1'b0);
    chk("R12 restarted count one byte", done_cnt - done_base, 1);
    chk("R12 restarted byte value", rx_byte, 8'h54);
    chk("R12 restarted byte addresses", addressed, 1);
    bus_stop(); host_pulse(0, 1'b0, 1'b0);

    // directed: arbitration kept when SDA matches
    host_pulse(2, 1'b1, 1'b1);
    bus_start(); bus_bit(1'b1);
    chk("R1 no loss when sda high", arb_lost, 0);
    chk("R1 still master", master_mode, 1);
    // arbitration lost
    bus_bit(1'b0);
    chk("R1 arb_lost set", arb_lost, 1);
    chk("R1 master cleared", master_mode, 0);
    chk("R1 trx cleared", transmit_mode, 0);
    chk("R3 halt follows loss", master_halt, 1);
    bus_stop();
    host_pulse(1, 1'b0, 1'b0);
    chk("R2 dbuf write clears arb_lost", arb_lost, 0);
    chk("R3 halt released", master_halt, 0);
    host_pulse(2, 1'b1, 1'b1);
    bus_start(); bus_bit(1'b0); bus_stop();
    chk("R1 second loss", arb_lost, 1);
    host_pulse(0, 1'b0, 1'b0);
    chk("R2 dbuf read clears arb_lost", arb_lost, 0);
    host_pulse(2, 1'b1, 1'b1);
    bus_start(); bus_bit(1'b0); bus_stop();
    host_pulse(2, 1'b1, 1'b0);
    chk("R2 ctrl2 clears arb_lost", arb_lost, 0);
    chk("R2 ctrl2 loads master", master_mode, 1);
    chk("R2 ctrl2 loads trx", transmit_mode, 0);
    // master mode: matching byte does not address
    bus_start(); bus_byte({7'h2A, 1'b0}, 1'b0);
    chk("R6 no addressing as master", addressed, 0);
    bus_stop();
    host_pulse(2, 1'b0, 1'b0);

    // random transactions
    for (int it = 0; it < 48; it++) begin
      a = 7'($urandom);
      f = 1'($urandom);
      ack = 1'($urandom);
      case ($urandom % 4)
        0: v = {a, 1'($urandom)};
        1: v = 8'h00;
        default: v = 8'($urandom);
      endcase
      slave_addr = a; addr_free = f;
      host_pulse(2, 1'b0, 1'b0);
      host_pulse(0, 1'b0, 1'b0);
      done_base = done_cnt;
      bus_start(); bus_byte(v, ack);
      chk(f ? "R7 free-mode addressed" : "R6 addressed vs address", addressed, exp_aas(v, a, f));
      chk("R4 random trx", transmit_mode, exp_trx(v, a, f));
      chk("R5 random general_call", general_call, v == 8'h00);
      chk("R10 random last_bit", last_bit, ack);
      chk("R11 random rx_byte", rx_byte, v);
      chk("R11 random byte count", done_cnt - done_base, 1);
      bus_byte(8'($urandom), 1'b1);
      chk("R11 second byte count", done_cnt - done_base, 2);
      bus_stop();
      chk("R9 random stop clears", general_call, 0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule